// File: doc/BRIEF.md
# Power-Good Delay and Margin Slew Sequencer

This block decides when a regulated rail may be declared good and steers a signed output-margin level for system test. It uses a single shared delay timer, a digital stand-in for a timing capacitor, for both jobs. After soft-start reports completion, the timer charges at a slow rate up to its full-scale threshold. The power-good level then rises and the timer is cleared. While power-good is high, the margining logic owns the same timer instead. It charges the timer at a rate fifty times faster and uses it to pace each margin change as a ramp, not a jump.

A window-comparator flag tells the block whether feedback sits inside the ±10% band around the reference. A violation must persist for a parameterized number of clock cycles before power-good falls. When power-good falls, the timer goes back to the power-good logic and the delay starts again. A mode bit selects between margining and tracking. In tracking mode the command pins are not decoded and the margin level is held at zero.

Top module: `pg_margin_seq`

## Requirements
- R1: Reset leaves `pg_good` low and `margin_lvl` at zero. `pg_good` rises only in a cycle where `ss_done` and `in_win` were both high at the previous edge. If the timer has reached full scale while `in_win` is low, `pg_good` waits and rises at the first edge that sees `in_win` high.
- R2: With `in_win` high, `pg_good` rises exactly `TMR_FULL * 50 * FAST_DIV + 1` clock edges after the first edge that samples `ss_done` high. It is still low one edge earlier.
- R3: If `ss_done` is low while `pg_good` is high, `pg_good` is low after the next edge. Once `ss_done` returns, the full delay of R2 is served again.
- R4: A run of fewer than `FILT_CYC` consecutive cycles with `in_win` low leaves `pg_good` high. A run of `FILT_CYC` such cycles brings `pg_good` low at the `FILT_CYC`-th edge. It rises again only after a full new delay counted from that edge.
- R5: In margining mode, the command is decoded as `{cmd_dn, cmd_up}`. 2'b00 targets zero, 2'b01 targets `+MARGIN_INC*TMR_FULL`, and 2'b10 targets `-MARGIN_INC*TMR_FULL`. 2'b11 keeps the present target.
- R6: While `pg_good` is high and the level differs from its target, the level moves by `MARGIN_INC` toward the target once every `FAST_DIV` cycles. A move from zero to either extreme therefore spans one full timer sweep of `TMR_FULL` fast ticks. The first move lands `FAST_DIV + 1` edges after the command edge.
- R7: A new command that arrives during a ramp redirects it from the present level, without restarting the ramp and without skipping to the old target.
- R8: When `mode_margin` is low, `margin_lvl` is zero after the next edge and stays zero whatever the command pins do.
- R9: While `pg_good` is low, `margin_lvl` does not change. A ramp that was in progress resumes after `pg_good` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_done | input | 1 | Soft-start ramp has completed |
| in_win | input | 1 | Feedback is inside the ±10% window |
| mode_margin | input | 1 | 1 selects margining, 0 selects tracking |
| cmd_dn | input | 1 | Command pin requesting a negative margin |
| cmd_up | input | 1 | Command pin requesting a positive margin |
| pg_good | output | 1 | Delayed, filtered power-good level |
| margin_lvl | output | MW | Signed margin level, ramped toward its target |

## Verification
The window filter can expire in the same edge that a fast margin tick lands. At that edge the timer changes owner while the level is in motion. The bench starts a ramp and then holds `in_win` low for exactly `FILT_CYC` cycles, timed so that the drop coincides with a move. It then checks three things: the last move is kept, the level freezes for the whole restarted delay, and `pg_good` returns exactly one full delay later. After that, the ramp must resume from the frozen value at the fast-rate spacing. A cycle-by-cycle margin model in the bench, built from R5 to R9, judges every cycle of this sequence as well as the explicit point checks.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    // Ratio between the fast margin-slew rate and the slow power-good rate.
    localparam int unsigned RATE_RATIO = 50;

    typedef enum logic [1:0] {
        TGT_NOM = 2'd0,
        TGT_UP  = 2'd1,
        TGT_DN  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pg_evt_t;

    // {dn, up}: 00 nominal, 01 raise, 10 lower, 11 keep current target.
    function automatic tgt_e decode_cmd(input logic dn, input logic up, input tgt_e cur);
        case ({dn, up})
            2'b00:   return TGT_NOM;
            2'b01:   return TGT_UP;
            2'b10:   return TGT_DN;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/pgm_tick.sv
module pgm_tick #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = run && (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
    parameter int unsigned FULL = 8,
    parameter int unsigned W    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         pg_own,
    input  logic         slow_tick,
    input  logic         fast_tick,
    output logic [W-1:0] count,
    output logic         full
);
    assign full = (count == W'(FULL));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (pg_own) begin
            // Power-good delay: charge slowly and hold at threshold.
            if (slow_tick && !full) begin
                count <= count + 1'b1;
            end
        end else if (fast_tick) begin
            // Margin pacing: one sweep per full-scale margin move, then restart.
            count <= (count == W'(FULL - 1)) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/pgm_pg_ctrl.sv
module pgm_pg_ctrl
    import pgm_pkg::*;
#(
    parameter int unsigned FILT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ss_done,
    input  logic    in_win,
    input  logic    tmr_full,
    output logic    pg,
    output pg_evt_t evt,
    output logic    slow_run
);
    localparam int unsigned FW = (FILT > 1) ? $clog2(FILT) : 1;

    logic [FW-1:0] bad_cnt;
    logic          trip;

    assign trip     = !in_win && (bad_cnt == FW'(FILT - 1));
    assign evt.rise = !pg && ss_done && tmr_full && in_win;
    assign evt.fall = pg && (!ss_done || trip);
    assign slow_run = !pg && ss_done && !tmr_full;

    always_ff @(posedge clk) begin
        if (rst || in_win) begin
            bad_cnt <= '0;
        end else if (bad_cnt != FW'(FILT - 1)) begin
            bad_cnt <= bad_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pg <= 1'b0;
        end else if (evt.rise) begin
            pg <= 1'b1;
        end else if (evt.fall) begin
            pg <= 1'b0;
        end
    end
endmodule

// File: rtl/pgm_margin.sv
module pgm_margin
    import pgm_pkg::*;
#(
    parameter int unsigned INC  = 3,
    parameter int unsigned FULL = 8,
    parameter int unsigned MW   = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode,
    input  logic                 cmd_dn,
    input  logic                 cmd_up,
    input  logic                 pg,
    input  logic                 fast_tick,
    output logic signed [MW-1:0] level,
    output logic                 fast_run
);
    localparam int unsigned MAG = INC * FULL;
    localparam logic signed [MW-1:0] POS_L = MW'(MAG);
    localparam logic signed [MW-1:0] NEG_L = -POS_L;
    localparam logic signed [MW-1:0] INC_L = MW'(INC);
    localparam logic signed [MW:0]   INC_S = (MW + 1)'(INC);

    tgt_e                 tgt;
    logic signed [MW-1:0] goal;
    logic signed [MW:0]   gap;
    logic signed [MW-1:0] nxt;

    always_comb begin
        case (tgt)
            TGT_UP:  goal = POS_L;
            TGT_DN:  goal = NEG_L;
            default: goal = '0;
        endcase
    end

    assign gap = {goal[MW-1], goal} - {level[MW-1], level};

    always_comb begin
        if (gap > INC_S) begin
            nxt = level + INC_L;
        end else if (gap < -INC_S) begin
            nxt = level - INC_L;
        end else begin
            nxt = goal;
        end
    end

    assign fast_run = pg && mode && (level != goal);

    always_ff @(posedge clk) begin
        if (rst || !mode) begin
            tgt   <= TGT_NOM;
            level <= '0;
        end else begin
            tgt <= decode_cmd(cmd_dn, cmd_up, tgt);
            if (fast_tick) begin
                level <= nxt;
            end
        end
    end
endmodule

// File: rtl/pg_margin_seq.sv
module pg_margin_seq
    import pgm_pkg::*;
#(
    parameter int unsigned FAST_DIV   = 2,
    parameter int unsigned TMR_FULL   = 8,
    parameter int unsigned FILT_CYC   = 4,
    parameter int unsigned MARGIN_INC = 3,
    localparam int unsigned MW = $clog2(MARGIN_INC * TMR_FULL + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ss_done,
    input  logic                 in_win,
    input  logic                 mode_margin,
    input  logic                 cmd_dn,
    input  logic                 cmd_up,
    output logic                 pg_good,
    output logic signed [MW-1:0] margin_lvl
);
    localparam int unsigned SLOW_DIV = FAST_DIV * RATE_RATIO;
    localparam int unsigned TW       = $clog2(TMR_FULL + 1);

    pg_evt_t       evt;
    logic          slow_run, fast_run;
    logic          slow_tick, fast_tick;
    logic          tmr_full, tmr_clr;
    logic [TW-1:0] tmr_count;

    pgm_tick #(.DIV(SLOW_DIV)) u_slow (
        .clk(clk), .rst(rst), .run(slow_run), .tick(slow_tick)
    );

    pgm_tick #(.DIV(FAST_DIV)) u_fast (
        .clk(clk), .rst(rst), .run(fast_run), .tick(fast_tick)
    );

    // Clear on every handover and whenever the current owner gives up its use.
    assign tmr_clr = evt.rise || evt.fall
                  || (!pg_good && !ss_done)
                  || (pg_good && !mode_margin);

    pgm_timer #(.FULL(TMR_FULL), .W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .pg_own   (!pg_good),
        .slow_tick(slow_tick),
        .fast_tick(fast_tick),
        .count    (tmr_count),
        .full     (tmr_full)
    );

    pgm_pg_ctrl #(.FILT(FILT_CYC)) u_pg (
        .clk     (clk),
        .rst     (rst),
        .ss_done (ss_done),
        .in_win  (in_win),
        .tmr_full(tmr_full),
        .pg      (pg_good),
        .evt     (evt),
        .slow_run(slow_run)
    );

    pgm_margin #(.INC(MARGIN_INC), .FULL(TMR_FULL), .MW(MW)) u_mgn (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_margin),
        .cmd_dn   (cmd_dn),
        .cmd_up   (cmd_up),
        .pg       (pg_good),
        .fast_tick(fast_tick),
        .level    (margin_lvl),
        .fast_run (fast_run)
    );
endmodule

// File: rtl/pgm_chk.sv
module pgm_chk #(
    parameter int unsigned TMR_FULL   = 8,
    parameter int unsigned FILT_CYC   = 4,
    parameter int unsigned MARGIN_INC = 3,
    parameter int unsigned MW         = 6,
    parameter int unsigned TW         = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ss_done,
    input logic                 in_win,
    input logic                 mode_margin,
    input logic                 pg_good,
    input logic signed [MW-1:0] margin_lvl,
    input logic [TW-1:0]        tmr_count
);
    logic [31:0]          bad_run;
    logic signed [MW-1:0] prev_lvl;
    logic                 prev_mode;
    logic signed [MW:0]   delta;

    always_ff @(posedge clk) begin
        if (rst || in_win) begin
            bad_run <= '0;
        end else if (bad_run < FILT_CYC) begin
            bad_run <= bad_run + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl  <= '0;
            prev_mode <= 1'b0;
        end else begin
            prev_lvl  <= margin_lvl;
            prev_mode <= mode_margin;
        end
    end

    assign delta = {margin_lvl[MW-1], margin_lvl} - {prev_lvl[MW-1], prev_lvl};

    a_r1_rise_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> $past(ss_done) && $past(in_win));

    a_r2_rise_at_full: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_good) |-> $past(tmr_count) == TW'(TMR_FULL));

    a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
        tmr_count <= TW'(TMR_FULL));

    a_r3_ss_drop: assert property (@(posedge clk) disable iff (rst)
        pg_good && !ss_done |=> !pg_good);

    a_r4_filter_len: assert property (@(posedge clk) disable iff (rst)
        $fell(pg_good) && $past(ss_done) |-> !$past(in_win) && ($past(bad_run) >= FILT_CYC - 1));

    a_r6_step_size: assert property (@(posedge clk) disable iff (rst)
        prev_mode |-> (delta <= $signed(MARGIN_INC)) && (delta >= -$signed(MARGIN_INC)));

    a_r8_track_zero: assert property (@(posedge clk) disable iff (rst)
        !mode_margin |=> margin_lvl == '0);

    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(pg_good) && $past(mode_margin) |-> $stable(margin_lvl));
endmodule

bind pg_margin_seq pgm_chk #(
    .TMR_FULL  (TMR_FULL),
    .FILT_CYC  (FILT_CYC),
    .MARGIN_INC(MARGIN_INC),
    .MW        (MW),
    .TW        (TW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ss_done    (ss_done),
    .in_win     (in_win),
    .mode_margin(mode_margin),
    .pg_good    (pg_good),
    .margin_lvl (margin_lvl),
    .tmr_count  (tmr_count)
);

// File: tb/sim_pg_margin_seq.sv
`timescale 1ns/1ps
module sim_pg_margin_seq;
    localparam int FD    = 2;
    localparam int FULL  = 8;
    localparam int FILT  = 4;
    localparam int INC   = 3;
    localparam int MAG   = INC * FULL;
    localparam int DELAY = FULL * 50 * FD + 1;
    localparam int MW    = $clog2(MAG + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ss_done = 1'b0, in_win = 1'b0, mode_margin = 1'b0, cmd_dn = 1'b0, cmd_up = 1'b0;
    logic pg_good;
    logic signed [MW-1:0] margin_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pg_margin_seq #(.FAST_DIV(FD), .TMR_FULL(FULL), .FILT_CYC(FILT), .MARGIN_INC(INC)) u0 (
        .clk(clk), .rst(rst), .ss_done(ss_done), .in_win(in_win),
        .mode_margin(mode_margin), .cmd_dn(cmd_dn), .cmd_up(cmd_up),
        .pg_good(pg_good), .margin_lvl(margin_lvl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_pg(input string req, input int exp);
        check(pg_good == exp[0], req, int'(pg_good), exp);
    endtask

    task automatic chk_lvl(input string req, input int exp);
        check(int'($signed(margin_lvl)) == exp, req, int'($signed(margin_lvl)), exp);
    endtask

    // Cycle model of the margin level built from R5..R9 (target decode, pacing, freeze).
    int m_tgt = 0, m_out = 0, m_fc = 0;
    bit b_run, b_tick;
    always @(posedge clk) begin
        if (rst || !mode_margin) begin
            m_tgt <= 0; m_out <= 0; m_fc <= 0;
        end else begin
            b_run  = pg_good && (m_out != m_tgt);
            b_tick = b_run && (m_fc == FD - 1);
            m_fc  <= (!b_run || b_tick) ? 0 : m_fc + 1;
            if (b_tick) begin
                if (m_tgt - m_out > INC)       m_out <= m_out + INC;
                else if (m_tgt - m_out < -INC) m_out <= m_out - INC;
                else                           m_out <= m_tgt;
            end
            case ({cmd_dn, cmd_up})
                2'b00:   m_tgt <= 0;
                2'b01:   m_tgt <= MAG;
                2'b10:   m_tgt <= -MAG;
                default: m_tgt <= m_tgt;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) chk_lvl("R6 per-cycle margin model", m_out);
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(4);
        chk_pg("R1 reset pg", 0);
        chk_lvl("R1 reset margin", 0);
        rst = 1'b0; mode_margin = 1'b1; in_win = 1'b1;
        step(40);
        chk_pg("R1 no soft-start", 0);

        // R2: delay from soft-start completion
        ss_done = 1'b1;
        step(DELAY - 1); chk_pg("R2 one edge early", 0);
        step(1);         chk_pg("R2 delay end", 1);

        // R6: ramp to +MAG
        cmd_up = 1'b1;
        step(2 * FULL); chk_lvl("R6 one move short", MAG - INC);
        step(1);        chk_lvl("R6 full sweep", MAG);

        // R5: decode and hold
        cmd_dn = 1'b1;  step(20); chk_lvl("R5 code 11 holds", MAG);
        cmd_dn = 1'b0; cmd_up = 1'b0; step(17); chk_lvl("R5 code 00 nominal", 0);
        cmd_dn = 1'b1;  step(17); chk_lvl("R5 code 10 negative", -MAG);

        // R7: retarget mid-ramp
        cmd_dn = 1'b0;  step(9);  chk_lvl("R7 mid ramp", -12);
        cmd_up = 1'b1;  step(23); chk_lvl("R7 redirected", 21);
        step(1);                  chk_lvl("R7 reached", MAG);

        // R8: tracking mode
        mode_margin = 1'b0; step(1); chk_lvl("R8 forced zero", 0);
        cmd_dn = 1'b1; cmd_up = 1'b0; step(10); chk_lvl("R8 pins ignored", 0);
        mode_margin = 1'b1; step(17); chk_lvl("R8 margining resumes", -MAG);

        // R4: short violation is filtered
        in_win = 1'b0; step(FILT - 1); chk_pg("R4 short violation", 1);
        in_win = 1'b1; step(2);        chk_pg("R4 after short", 1);

        // R4 + R9: filter expiry coincides with a margin move
        cmd_dn = 1'b0; step(5);
        in_win = 1'b0; step(FILT - 1); chk_pg("R4 not yet", 1);
        step(1);       chk_pg("R4 filter expiry", 0);
        chk_lvl("R9 last move kept", -12);
        in_win = 1'b1; step(50);       chk_lvl("R9 frozen", -12);
        step(DELAY - 51);              chk_pg("R4 full delay again", 0);
        step(1);                       chk_pg("R4 re-rise", 1);
        step(7);                       chk_lvl("R9 ramp resumed", -3);
        step(1);                       chk_lvl("R9 ramp done", 0);

        // R3 and R1 window gating
        ss_done = 1'b0; step(1);  chk_pg("R3 soft-start drop", 0);
        step(5);
        ss_done = 1'b1; in_win = 1'b0;
        step(DELAY - 1);          chk_pg("R3 delay restarts", 0);
        step(5);                  chk_pg("R1 window gates rise", 0);
        in_win = 1'b1; step(1);   chk_pg("R1 rise on window", 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule